// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps the time of day as six BCD digits, hours, minutes and seconds (HH:MM:SS), running from a free-running system clock. A built-in time base divides the system clock down to one advance per second. Each digit is a 4-bit binary counter stage cut short to its own modulus: ten for the units digits, six for the tens of seconds and minutes, and a combined 24-hour limit on the hours pair. The stages form a chain: a digit steps only when every digit below it sits at its last value. Together they form a carry chain, so two decimal stages make a mod-100 counter.

All stages share one clock edge and use clock enables instead of rippled clocks, so every digit changes on the same edge. The time base is a counter followed by a toggle flip-flop. The counter's narrow terminal pulse flips the toggle, which gives a 50 % duty square wave at the one-second rate. One full toggle period makes one seconds advance. A one-cycle strobe marks each advance. A run enable freezes the time base and the digits, and a synchronous reset returns everything to 00:00:00. The number of system clocks per second is a parameter, so a bench can use a small value.

Top module: `tod_bcd_counter`

## Requirements
- R1: While `rst` is high at a rising edge, every digit output becomes 0, `sec_tick` becomes 0 and `half_sec_wave` becomes 0, whatever `run_en` is.
- R2: With `run_en` held high, the time value advances by exactly one second after every CLK_PER_SEC enabled clock edges, counted from reset. Between advances every digit holds.
- R3: `sec_units` and `min_units` each count 0 to 9 and go from 9 back to 0 on the next advance. No digit output ever shows a value above 9.
- R4: `sec_tens` and `min_tens` count 0 to 5 and go from 5 back to 0. Minutes go from 59 to 00 when a carry arrives from the seconds.
- R5: A digit steps only on an advance where every lower digit is at its last value: 9 for units, 5 for tens of seconds or minutes, or the hours-pair limit. Otherwise it holds.
- R6: The hours pair counts 00 to 23. At 23:59:59 the next advance gives 00:00:00. `hour_tens` never exceeds 2, and when it is 2, `hour_units` never exceeds 3.
- R7: When `hour_units` goes from 9 to 0, `hour_tens` increases by one on the same edge. This gives 09:59:59 to 10:00:00 and 19:59:59 to 20:00:00.
- R8: While `run_en` is low, the time base and all digits hold, `half_sec_wave` holds, and `sec_tick` is 0 after the first such edge.
- R9: `half_sec_wave` inverts after every CLK_PER_SEC/2 enabled edges. It is 1 after an odd number of such half periods since reset and 0 after an even number, so it is a 50 % duty square wave.
- R10: `sec_tick` is high for exactly the one cycle in which a new seconds value is first visible on the digit outputs, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to 00:00:00 |
| run_en | input | 1 | Lets the time base and the digit chain run when high |
| sec_units | output | 4 | BCD units of seconds |
| sec_tens | output | 4 | BCD tens of seconds |
| min_units | output | 4 | BCD units of minutes |
| min_tens | output | 4 | BCD tens of minutes |
| hour_units | output | 4 | BCD units of hours |
| hour_tens | output | 4 | BCD tens of hours |
| sec_tick | output | 1 | One-cycle strobe with each seconds advance |
| half_sec_wave | output | 1 | Square wave from the time-base toggle, one period per second |

## Verification
Several functions can act on the same edge. The hours-pair limit at 23 and the ordinary units carry both reach `hour_units` and `hour_tens` at once. A seconds advance is also the edge on which `sec_tick` rises and the time-base toggle falls. The bench provokes all of these by sweeping an entire day, plus a few seconds past midnight, with a two-cycle second. For every cycle it computes the expected digits, strobe and wave from the count of enabled edges. It also inserts pauses of `run_en` right next to advances to show that the freeze wins over a pending carry.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef logic [3:0] bcd_t;

  // number of digit stages below the hours pair
  localparam int unsigned LOW_STAGES = 4;
  // hours-pair limit (23)
  localparam int unsigned HOUR_TENS_LAST  = 2;
  localparam int unsigned HOUR_UNITS_LIMIT = 3;

  // even stage index -> units digit (mod 10), odd -> tens digit (mod 6)
  function automatic int unsigned low_stage_mod(input int unsigned idx);
    return (idx % 2 == 0) ? 10 : 6;
  endfunction
endpackage

// File: rtl/tod_timebase.sv
module tod_timebase #(
  parameter int unsigned CLK_PER_SEC = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic sec_en,
  output logic wave
);
  localparam int unsigned HALF = CLK_PER_SEC / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] div_cnt;
  logic          div_tc;
  logic          tgl;

  assign div_tc = run_en && (div_cnt == CNT_LAST);
  // the toggle falling edge closes one full period: one second
  assign sec_en = div_tc && tgl;
  assign wave   = tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tgl     <= 1'b0;
    end else if (div_tc) begin
      div_cnt <= '0;
      tgl     <= ~tgl;
    end else if (run_en) begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= CNT_LAST);

  // R8
  div_freeze_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(run_en) |-> ($stable(div_cnt) && $stable(tgl)));

  // R9
  wave_flip_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (tgl != $past(tgl)) |-> $past(div_tc));
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import tod_pkg::*;
#(
  parameter int unsigned MODULUS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic wrap_now,
  output bcd_t q,
  output logic at_last
);
  localparam bcd_t LAST = 4'(MODULUS - 1);

  assign at_last = (q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (step) begin
      if (at_last || wrap_now) q <= '0;
      else                     q <= q + 1'b1;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R3
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    q <= LAST);

  // R5
  digit_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(step) |-> $stable(q));

  // R4
  digit_wrap_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(step) && $past(q) == LAST) |-> (q == '0));
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
  import tod_pkg::*;
#(
  parameter int unsigned CLK_PER_SEC = 125_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_en,
  output logic [3:0] sec_units,
  output logic [3:0] sec_tens,
  output logic [3:0] min_units,
  output logic [3:0] min_tens,
  output logic [3:0] hour_units,
  output logic [3:0] hour_tens,
  output logic       sec_tick,
  output logic       half_sec_wave
);
  logic sec_en;

  tod_timebase #(.CLK_PER_SEC(CLK_PER_SEC)) timebase_i (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .sec_en (sec_en),
    .wave   (half_sec_wave)
  );

  // carry chain through the low stages
  logic [LOW_STAGES:0] carry;
  bcd_t                low_q    [LOW_STAGES];
  logic [LOW_STAGES-1:0] low_last;

  assign carry[0] = sec_en;

  for (genvar g = 0; g < LOW_STAGES; g++) begin : g_low
    bcd_digit_stage #(.MODULUS(low_stage_mod(g))) stage_i (
      .clk      (clk),
      .rst      (rst),
      .step     (carry[g]),
      .wrap_now (1'b0),
      .q        (low_q[g]),
      .at_last  (low_last[g])
    );
    assign carry[g+1] = carry[g] && low_last[g];
  end

  // hours pair with 24-hour limit
  bcd_t hu_q, ht_q;
  logic hu_last, ht_last, at_limit, ht_step;

  assign at_limit = ht_last && (hu_q == 4'(HOUR_UNITS_LIMIT));
  assign ht_step  = carry[LOW_STAGES] && (hu_last || at_limit);

  bcd_digit_stage #(.MODULUS(10)) hour_units_i (
    .clk      (clk),
    .rst      (rst),
    .step     (carry[LOW_STAGES]),
    .wrap_now (at_limit),
    .q        (hu_q),
    .at_last  (hu_last)
  );

  bcd_digit_stage #(.MODULUS(HOUR_TENS_LAST + 1)) hour_tens_i (
    .clk      (clk),
    .rst      (rst),
    .step     (ht_step),
    .wrap_now (at_limit),
    .q        (ht_q),
    .at_last  (ht_last)
  );

  always_ff @(posedge clk) begin
    if (rst) sec_tick <= 1'b0;
    else     sec_tick <= sec_en;
  end

  assign sec_units  = low_q[0];
  assign sec_tens   = low_q[1];
  assign min_units  = low_q[2];
  assign min_tens   = low_q[3];
  assign hour_units = hu_q;
  assign hour_tens  = ht_q;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R6
  hour_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (hour_tens == 4'(HOUR_TENS_LAST)) |-> (hour_units <= 4'(HOUR_UNITS_LIMIT)));

  // R6
  hour_tens_range_chk: assert property (@(posedge clk) disable iff (rst)
    hour_tens <= 4'(HOUR_TENS_LAST));

  // R10
  tick_value_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    sec_tick |-> (sec_units != $past(sec_units)));

  // R8
  tick_freeze_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(run_en) |-> !sec_tick);

  // R7
  hour_carry_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(hour_units) == 4'd9 && hour_units == 4'd0)
      |-> (hour_tens == $past(hour_tens) + 4'd1));
endmodule

// File: tb/tod_bcd_counter_tb_top.sv
module tod_bcd_counter_tb_top;
  localparam int unsigned CPS = 2;
  localparam int DAY = 86400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [3:0] su, st, mu, mt, hu, ht;
  logic tick, wave;

  always #4 clk = ~clk;

  tod_bcd_counter #(.CLK_PER_SEC(CPS)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en),
    .sec_units(su), .sec_tens(st), .min_units(mu), .min_tens(mt),
    .hour_units(hu), .hour_tens(ht),
    .sec_tick(tick), .half_sec_wave(wave)
  );

  int checks = 0;
  int failures = 0;
  int n_en = 0;
  bit done = 1'b0;

  function automatic logic [23:0] pack_time(input int secs);
    int t, h, m, s;
    t = secs % DAY;
    h = t / 3600;
    m = (t / 60) % 60;
    s = t % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  function automatic string pick_tag(input int prev, input int cur);
    if (prev == cur)                        return "R2";
    if (cur == 0)                           return "R6";
    if (prev % 36000 == 35999)              return "R7";
    if (prev % 3600 == 3599)                return "R4";
    if (prev % 60 == 59)                    return "R5";
    if (prev % 10 == 9)                     return "R3";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h at n=%0d", tag, got, exp, n_en);
    end
  endtask

  task automatic check_all(input string tag, input int prev_secs, input bit exp_tick);
    int cur;
    cur = (n_en / int'(CPS)) % DAY;
    chk(tag == "" ? pick_tag(prev_secs, cur) : tag, {ht, hu, mt, mu, st, su}, pack_time(cur));
    chk("R10", {23'd0, tick}, {23'd0, exp_tick});
    chk("R9", {23'd0, wave}, {23'd0, 1'(n_en % 2)});
  endtask

  // one clock: inputs set at negedge, sampled at the next negedge
  task automatic step(input bit en, input string tag);
    int prev;
    bit tk;
    prev = (n_en / int'(CPS)) % DAY;
    run_en = en;
    @(posedge clk);
    if (en) n_en++;
    tk = en && (n_en % int'(CPS) == 0);
    @(negedge clk);
    check_all(tag, prev, tk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state with run_en high as well
    run_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {ht, hu, mt, mu, st, su}, 24'h0);
    chk("R1", {22'd0, tick, wave}, 24'h0);
    rst = 1'b0;
    run_en = 1'b0;
    n_en = 0;

    // whole day plus a few seconds past midnight, with pauses
    for (int i = 0; i < DAY * int'(CPS) + 20; i++) begin
      if (i % 40000 == 20001 || i == DAY * int'(CPS) - 1) begin
        for (int k = 0; k < 3; k++) step(1'b0, "R8");
      end
      step(1'b1, "");
    end

    // reset in the middle of running (R1)
    rst = 1'b1;
    run_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", {ht, hu, mt, mu, st, su}, 24'h0);
    chk("R1", {22'd0, tick, wave}, 24'h0);
    rst = 1'b0;
    n_en = 0;
    for (int i = 0; i < 6; i++) step(1'b1, "");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule